// File: doc/BRIEF.md
# Page-Buffered Write Sequencer with Busy Polling

This block is the storage-side back end of a two-wire serial memory slave. The protocol engine hands it an address load when the address byte of a write arrives. It then hands over one strobe per acknowledged data byte, followed by the STOP event. The block holds up to one page of 16 bytes, with a valid flag for each byte. On STOP it runs a self-timed programming cycle into the memory array. The cycle first clears every entered byte to all ones, waits a settle interval, and then writes the buffered values. Bytes of the page that were not entered receive no array access.

While the cycle runs, the block raises a busy flag and a command-refusal signal. The protocol engine uses that signal to leave every command byte unacknowledged, so a bus master can poll for completion. A STOP does not start a cycle if the write-protect pin is high, if the page is marked protected, or if no data byte was entered. The settle interval is a clock count that stands in for the multi-millisecond timing of a real cell.

Top module: `pw_page_writer`

## Requirements
- R1: After reset, `busy`, `nack_cmd` and `arr_we` are low and `cur_addr` is 0.
- R2: Each accepted byte strobe stores `byte_data` for in-page offset `cur_addr[3:0]`. It then increments only `cur_addr[3:0]`, wrapping from 15 to 0, and leaves page bits `cur_addr[10:4]` unchanged.
- R3: When more than 16 bytes are entered, a later byte replaces the earlier byte at the same wrapped offset, and only the latest value is programmed.
- R4: A STOP with at least one entered byte, `wp_pin` low and `page_locked` low raises `busy` from the next cycle for exactly 32 + `SETTLE_CLKS` cycles.
- R5: Each entered byte gets exactly two array writes, the value 8'hFF first and its buffered value second. Every clearing write of a cycle comes before any data write of that cycle. Unentered addresses receive no write.
- R6: `nack_cmd` is high exactly while `busy` is high, and `arr_we` is never high without `nack_cmd`.
- R7: After a programming cycle ends, `cur_addr` holds the address of the last entered byte.
- R8: A STOP while `wp_pin` is high starts no cycle. `busy` stays low and the array receives no write.
- R9: A STOP while `page_locked` is high (the page's protection bit is written) starts no cycle and produces no array write.
- R10: A STOP with no byte entered since the last address load starts no cycle.
- R11: Byte strobes and address loads that arrive while `busy` is high are ignored. They change neither the programmed data nor `cur_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Address byte received; load `load_addr` |
| load_addr | input | 11 | Full byte address (page bits and offset) |
| byte_strobe | input | 1 | One acknowledged data byte |
| byte_data | input | 8 | Data byte value |
| stop_evt | input | 1 | STOP condition seen on the bus |
| wp_pin | input | 1 | Write-protect pin; high blocks programming |
| page_locked | input | 1 | High when the current page's protection bit is written |
| busy | output | 1 | Programming cycle in progress |
| nack_cmd | output | 1 | Tells the protocol engine to refuse command bytes |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 11 | Array write address |
| arr_wdata | output | 8 | Array write data |
| cur_addr | output | 11 | Internal address counter |

## Verification
A vector table drives a single-byte write, a full 16-byte page, an entry that starts near the top of a page and wraps, and a 20-byte entry that overflows the buffer. Comparing array traffic against a model separates correct in-page wrapping from carry into the page bits. It also shows whether only the latest value lands at an overwritten offset, and whether untouched bytes stay free of writes. Further vectors raise write protect, raise the page lock, or send a bare STOP, and each must produce no cycle at all. Directed cases then check the reset state and the busy window length, and confirm that strobes arriving during a cycle leave both the data and the counter unchanged.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ERASE  = 2'd1,
    SEQ_SETTLE = 2'd2,
    SEQ_WRITE  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/pw_addr_ctr.sv
module pw_addr_ctr #(
  parameter int ADDR_W = 11,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  input  logic              restore,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] last_q, last_d;
  logic              ptr_en, last_en;

  always_comb begin
    ptr_d   = ptr_q;
    last_d  = last_q;
    ptr_en  = 1'b0;
    last_en = 1'b0;
    if (load) begin
      ptr_d  = load_addr;
      ptr_en = 1'b1;
    end else if (step) begin
      ptr_d   = {ptr_q[ADDR_W-1:OFF_W], ptr_q[OFF_W-1:0] + 1'b1};
      ptr_en  = 1'b1;
      last_d  = ptr_q;
      last_en = 1'b1;
    end else if (restore) begin
      ptr_d  = last_q;
      ptr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      last_q <= '0;
    end else begin
      if (ptr_en)  ptr_q  <= ptr_d;
      if (last_en) last_q <= last_d;
    end
  end

  assign cur_addr = ptr_q;

  // R2
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cur_addr[ADDR_W-1:OFF_W] == $past(cur_addr[ADDR_W-1:OFF_W])));

  logic [PAGE_W-1:0] unused_page;
  assign unused_page = last_q[ADDR_W-1:OFF_W];
endmodule

// File: rtl/pw_page_buf.sv
module pw_page_buf #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              any_valid
);
  localparam int SLOTS = 1 << OFF_W;

  logic [DATA_W-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0]  vld_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_off == OFF_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[s] <= '0;
      else if (hit) slot_q[s] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_q[s] <= 1'b0;
      else if (clr) vld_q[s] <= 1'b0;
      else if (hit) vld_q[s] <= 1'b1;
    end
  end

  assign rd_data   = slot_q[rd_off];
  assign rd_valid  = vld_q[rd_off];
  assign any_valid = |vld_q;

  // R10
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !any_valid);
endmodule

// File: rtl/pw_seq.sv
module pw_seq
  import pw_pkg::*;
#(
  parameter int OFF_W       = 4,
  parameter int SETTLE_CLKS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             erase_ph,
  output logic             write_ph,
  output logic [OFF_W-1:0] scan_idx,
  output logic             done
);
  localparam int TMR_W = (SETTLE_CLKS > 1) ? $clog2(SETTLE_CLKS) : 1;
  localparam logic [OFF_W-1:0] LAST_IDX = '1;
  localparam logic [TMR_W-1:0] TMR_END  = TMR_W'(SETTLE_CLKS - 1);

  seq_state_t        st_q, st_d;
  logic [OFF_W-1:0]  idx_q, idx_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    tmr_d = tmr_q;
    done  = 1'b0;
    case (st_q)
      SEQ_IDLE: if (start) begin
        st_d  = SEQ_ERASE;
        idx_d = '0;
      end
      SEQ_ERASE: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == LAST_IDX) begin
          st_d  = SEQ_SETTLE;
          tmr_d = '0;
        end
      end
      SEQ_SETTLE: begin
        tmr_d = tmr_q + 1'b1;
        if (tmr_q == TMR_END) begin
          st_d  = SEQ_WRITE;
          idx_d = '0;
        end
      end
      SEQ_WRITE: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == LAST_IDX) begin
          st_d = SEQ_IDLE;
          done = 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      idx_q <= '0;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      tmr_q <= tmr_d;
    end
  end

  assign busy     = (st_q != SEQ_IDLE);
  assign erase_ph = (st_q == SEQ_ERASE);
  assign write_ph = (st_q == SEQ_WRITE);
  assign scan_idx = idx_q;

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R5
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_ph, write_ph}));
endmodule

// File: rtl/pw_page_writer.sv
module pw_page_writer #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int OFF_W       = 4,
  parameter int SETTLE_CLKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              byte_strobe,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_evt,
  input  logic              wp_pin,
  input  logic              page_locked,
  output logic              busy,
  output logic              nack_cmd,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic [ADDR_W-1:0] cur_addr
);
  logic             accept, do_load, do_step, do_start, do_clr;
  logic             any_valid, rd_valid, erase_ph, write_ph, seq_done;
  logic [OFF_W-1:0] scan_idx;
  logic [DATA_W-1:0] rd_data;

  assign accept   = !busy;
  assign do_load  = addr_load && accept;
  assign do_step  = byte_strobe && accept && !addr_load;
  assign do_start = stop_evt && accept && any_valid && !wp_pin && !page_locked;
  assign do_clr   = do_load || (stop_evt && accept && !do_start) || seq_done;

  pw_addr_ctr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_ctr (
    .clk(clk), .rst_n(rst_n), .load(do_load), .load_addr(load_addr),
    .step(do_step), .restore(seq_done), .cur_addr(cur_addr)
  );

  pw_page_buf #(.DATA_W(DATA_W), .OFF_W(OFF_W)) i_buf (
    .clk(clk), .rst_n(rst_n), .clr(do_clr), .wr_en(do_step),
    .wr_off(cur_addr[OFF_W-1:0]), .wr_data(byte_data), .rd_off(scan_idx),
    .rd_data(rd_data), .rd_valid(rd_valid), .any_valid(any_valid)
  );

  pw_seq #(.OFF_W(OFF_W), .SETTLE_CLKS(SETTLE_CLKS)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(do_start), .busy(busy),
    .erase_ph(erase_ph), .write_ph(write_ph), .scan_idx(scan_idx), .done(seq_done)
  );

  assign nack_cmd  = busy;
  assign arr_we    = (erase_ph || write_ph) && rd_valid;
  assign arr_addr  = {cur_addr[ADDR_W-1:OFF_W], scan_idx};
  assign arr_wdata = erase_ph ? {DATA_W{1'b1}} : rd_data;

  // R6
  we_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> nack_cmd);

  // R8
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && wp_pin && !busy) |=> !busy);

  // R9
  lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && page_locked && !busy) |=> !busy);

  // R11
  busy_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_done) |=> $stable(cur_addr));
endmodule

// File: tb/test_pw_page_writer.sv
module test_pw_page_writer;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int SETTLE = 24;
  localparam int BUSY_LEN = 32 + SETTLE;
  localparam int NV = 7;

  // vectors: start address, byte count, data seed, wp, lock, expect programming
  localparam int V_ADDR [NV] = '{'h123, 'h2A0, 'h7FC, 'h455, 'h100, 'h310, 'h050};
  localparam int V_CNT  [NV] = '{1, 16, 6, 20, 4, 3, 0};
  localparam int V_SEED [NV] = '{'h3C, 'h10, 'hA1, 'h40, 'h55, 'h66, 'h77};
  localparam int V_WP   [NV] = '{0, 0, 0, 0, 1, 0, 0};
  localparam int V_LOCK [NV] = '{0, 0, 0, 0, 0, 1, 0};
  localparam int V_PROG [NV] = '{1, 1, 1, 1, 0, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_load = 1'b0, byte_strobe = 1'b0, stop_evt = 1'b0;
  logic wp_pin = 1'b0, page_locked = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [DW-1:0] byte_data = '0;
  logic busy, nack_cmd, arr_we;
  logic [AW-1:0] arr_addr, cur_addr;
  logic [DW-1:0] arr_wdata;

  always #4 clk = ~clk;

  pw_page_writer #(.SETTLE_CLKS(SETTLE)) i_pw_page_writer (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .load_addr(load_addr),
    .byte_strobe(byte_strobe), .byte_data(byte_data), .stop_evt(stop_evt),
    .wp_pin(wp_pin), .page_locked(page_locked), .busy(busy), .nack_cmd(nack_cmd),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .cur_addr(cur_addr)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int wcnt [2048];
  int wfirst [2048];
  int wlast [2048];
  int wtotal, busy_cyc, order_err, nack_err;
  bit saw_data;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    for (int a = 0; a < 2048; a++) begin
      wcnt[a] = 0; wfirst[a] = 0; wlast[a] = 0;
    end
    wtotal = 0; busy_cyc = 0; order_err = 0; nack_err = 0; saw_data = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cyc++;
      if (nack_cmd !== busy) nack_err++;
      if (arr_we) begin
        if (!nack_cmd) nack_err++;
        if (wcnt[arr_addr] == 0) begin
          wfirst[arr_addr] = arr_wdata;
          if (saw_data) order_err++;
        end else saw_data = 1;
        wcnt[arr_addr]++;
        wlast[arr_addr] = arr_wdata;
        wtotal++;
      end
    end
  end

  task automatic pulse_load(input int a);
    @(negedge clk); addr_load = 1; load_addr = AW'(a);
    @(negedge clk); addr_load = 0;
  endtask
  task automatic pulse_byte(input int d);
    @(negedge clk); byte_strobe = 1; byte_data = DW'(d);
    @(negedge clk); byte_strobe = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop_evt = 1;
    @(negedge clk); stop_evt = 0;
  endtask
  task automatic settle();
    for (int k = 0; k < BUSY_LEN + 10; k++) @(negedge clk);
  endtask

  initial begin
    int exp_val [16];
    bit entered [16];
    int base, page, nent, lastoff;
    clear_mon();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && nack_cmd == 0, "R1 busy/nack at reset", {busy, nack_cmd}, 0);
    check(arr_we == 0, "R1 arr_we at reset", arr_we, 0);
    check(cur_addr == 0, "R1 cur_addr at reset", cur_addr, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      clear_mon();
      wp_pin = V_WP[v][0]; page_locked = V_LOCK[v][0];
      base = V_ADDR[v]; page = base & 'h7F0;
      for (int o = 0; o < 16; o++) begin entered[o] = 0; exp_val[o] = 0; end
      nent = 0; lastoff = 0;
      pulse_load(base);
      for (int i = 0; i < V_CNT[v]; i++) begin
        int off, d;
        off = (base + i) & 15; d = (V_SEED[v] + i * 13) & 'hFF;
        if (!entered[off]) nent++;
        entered[off] = 1; exp_val[off] = d; lastoff = off;
        pulse_byte(d);
        // R2 in-page increment keeps page bits
        check(cur_addr == (page | ((base + i + 1) & 15)), "R2 counter step", cur_addr,
              page | ((base + i + 1) & 15));
      end
      pulse_stop();
      settle();
      if (V_PROG[v] != 0) begin
        // R4 busy window length
        check(busy_cyc == BUSY_LEN, "R4 busy length", busy_cyc, BUSY_LEN);
        // R5 writes per entered byte: FF then data; R3 last value wins
        for (int o = 0; o < 16; o++) begin
          if (entered[o]) begin
            check(wcnt[page | o] == 2 && wfirst[page | o] == 'hFF, "R5 erase then write",
                  wcnt[page | o], 2);
            check(wlast[page | o] == exp_val[o], (V_CNT[v] > 16) ? "R3 overwrite value" : "R2 data",
                  wlast[page | o], exp_val[o]);
          end
        end
        check(wtotal == 2 * nent, "R5 no writes to unentered bytes", wtotal, 2 * nent);
        check(order_err == 0, "R5 erase before data", order_err, 0);
        // R7 counter on last entered byte
        check(cur_addr == (page | lastoff), "R7 counter after cycle", cur_addr, page | lastoff);
      end else begin
        check(busy_cyc == 0 && wtotal == 0,
              (V_WP[v] != 0) ? "R8 wp blocks" : (V_LOCK[v] != 0) ? "R9 lock blocks" : "R10 empty stop",
              busy_cyc + wtotal, 0);
      end
      check(nack_err == 0, "R6 nack tracks busy", nack_err, 0);
    end
    wp_pin = 0; page_locked = 0;

    // R11 strobes during busy are ignored
    clear_mon();
    pulse_load('h600);
    pulse_byte('h21);
    pulse_byte('h22);
    pulse_stop();
    repeat (5) @(negedge clk);
    check(busy == 1, "R4 busy after stop", busy, 1);
    pulse_byte('h99);
    pulse_load('h700);
    pulse_byte('h98);
    settle();
    check(wtotal == 4 && wlast['h600] == 'h21 && wlast['h601] == 'h22,
          "R11 data unaffected", wtotal, 4);
    check(cur_addr == 'h601, "R11 counter unaffected", cur_addr, 'h601);

    // R10 address-only write after a completed cycle
    clear_mon();
    pulse_load('h3A0);
    pulse_stop();
    settle();
    check(busy_cyc == 0 && wtotal == 0, "R10 address-only stop", busy_cyc + wtotal, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule